// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is the control port of a frequency-synthesizer controller. A host shifts words into it over a three-wire serial link: a clock, a data line and an enable. Data arrives most significant bit first. There are no address bits. When the enable drops, the number of bits received picks the target register. An 8-bit transfer sets the configuration byte. A 16-bit transfer fills a holding buffer for the reference divider. A 24-bit transfer carries the main and swallow divide values.

New divide values never reach the counters in the middle of a count. A 24-bit write is held as pending. It moves to the main and swallow outputs on the next divide-reload strobe. The same 24-bit write also arms the held reference value. That value moves to the reference output on the next reference-reload strobe. This way a reference ratio and a main/swallow ratio can be retuned as one set.

The serial inputs are sampled by the system clock through a synchronizer. A configuration bit can turn the general-purpose output pin into a serial data-out. This lets a second device be chained on the same bus.

Top module: `synth_serial_loader`

## Requirements
- R1: A transfer of exactly 8 bits loads those bits into `cfg_q` when the enable falls. Bits are taken most significant bit first.
- R2: A transfer of any count other than 8, 16 or 24 (and not above 24) is discarded. `cfg_q`, `ref_div`, `main_div` and `swal_div` keep their values, even after reload strobes.
- R3: A transfer of exactly 24 bits is split into three fields. Bits 23..12 are the main value. Bits 5..0 are the swallow value. Bits 11..6 are reserved and ignored. These values appear on `main_div`/`swal_div` only one cycle after a `div_reload` pulse that follows the transfer. A `ref_reload` pulse does not apply them.
- R4: A 16-bit transfer only fills the reference holding buffer. `ref_div` stays unchanged through `ref_reload` pulses until a later 24-bit transfer arms the buffer. The next `ref_reload` pulse after that puts the buffer on `ref_div`.
- R5: A transfer longer than 24 bits is treated as a 24-bit divide write built from the last 24 bits received.
- R6: With `cfg_q[6]` set, `ser_out` carries the bit that entered the shift path 24 serial clocks earlier. This is the chaining output.
- R7: With `cfg_q[6]` clear, `ser_out` equals `cfg_q[0]`.
- R8: After reset, `cfg_q` is 8'h80 (bit 7 = standby), `ref_div` is 5, `main_div` is 5, `swal_div` is 0 and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data in, MSB first |
| ser_en | input | 1 | Transfer enable, active high; its fall ends a transfer |
| ref_reload | input | 1 | Reference counter reload point (one-cycle pulse) |
| div_reload | input | 1 | Main/swallow counter reload point (one-cycle pulse) |
| cfg_q | output | 8 | Configuration byte |
| ref_div | output | 16 | Live reference divide value |
| main_div | output | 12 | Live main divide value |
| swal_div | output | 6 | Live swallow divide value |
| ser_out | output | 1 | General-purpose output or chained serial data out |

## Verification
The hardest state to reach is an armed reference value that has not yet been applied. Reaching it takes a 16-bit write, then reference reload pulses to show nothing has moved, then a 24-bit write, and only then the reload that applies it. The bench runs that exact order. It also separates the two reload strobes so that each one is seen to move only its own outputs. The chaining path is reached by first setting the data-out mode with a configuration write. A known 24-bit pattern is then pushed through, followed by a short, discarded transfer that shifts the pattern further along.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
    localparam int CFG_W  = 8;
    localparam int REF_W  = 16;
    localparam int MAIN_W = 12;
    localparam int SWAL_W = 6;
    localparam int DIV_W  = 24;

    localparam int CFG_STANDBY_BIT = 7;
    localparam int CFG_DOUT_BIT    = 6;
    localparam int CFG_GPO_BIT     = 0;

    localparam logic [CFG_W-1:0]  CFG_RESET  = 8'h80;
    localparam logic [REF_W-1:0]  REF_MIN    = 16'd5;
    localparam logic [MAIN_W-1:0] MAIN_MIN   = 12'd5;
    localparam logic [SWAL_W-1:0] SWAL_MIN   = 6'd0;

    localparam int CNT_MAX = DIV_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CFG,
        TGT_REF,
        TGT_DIV
    } target_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main_v;
        logic [SWAL_W-1:0] swal_v;
    } div_word_t;

    function automatic target_e pick_target(input logic [CNT_W-1:0] n);
        if (n == CNT_W'(CFG_W))      return TGT_CFG;
        else if (n == CNT_W'(REF_W)) return TGT_REF;
        else if (n >= CNT_W'(DIV_W)) return TGT_DIV;
        else                         return TGT_NONE;
    endfunction

    function automatic div_word_t split_word(input logic [DIV_W-1:0] w);
        div_word_t d;
        d.main_v = w[DIV_W-1 -: MAIN_W];
        d.swal_v = w[SWAL_W-1:0];
        return d;
    endfunction
endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] din,      // {en, dat, sclk}
    output logic       sclk_rise,
    output logic       en_rise,
    output logic       en_fall,
    output logic       dat
);
    logic [2:0] pipe [STAGES];
    logic [2:0] last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            last <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            last <= pipe[STAGES-1];
        end
    end

    assign sclk_rise = pipe[STAGES-1][0] & ~last[0] & pipe[STAGES-1][2];
    assign en_rise   = pipe[STAGES-1][2] & ~last[2];
    assign en_fall   = ~pipe[STAGES-1][2] & last[2];
    assign dat       = pipe[STAGES-1][1];
endmodule

// File: rtl/ssl_shifter.sv
module ssl_shifter
    import ssl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift,
    input  logic             dat,
    output logic [DIV_W-1:0] shreg,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (shift) begin
            shreg <= {shreg[DIV_W-2:0], dat};
            if (cnt < CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssl_stager.sv
module ssl_stager
    import ssl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  target_e           tgt,
    input  logic [DIV_W-1:0]  word,
    input  logic              ref_reload,
    input  logic              div_reload,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [REF_W-1:0]  ref_div,
    output div_word_t         div_live
);
    logic [REF_W-1:0] ref_hold, ref_pend;
    logic             ref_armed;
    div_word_t        div_pend;
    logic             div_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            ref_hold  <= REF_MIN;
            ref_pend  <= REF_MIN;
            ref_armed <= 1'b0;
            ref_div   <= REF_MIN;
            div_pend  <= '{main_v: MAIN_MIN, swal_v: SWAL_MIN};
            div_armed <= 1'b0;
            div_live  <= '{main_v: MAIN_MIN, swal_v: SWAL_MIN};
        end else begin
            if (div_reload && div_armed) begin
                div_live  <= div_pend;
                div_armed <= 1'b0;
            end
            if (ref_reload && ref_armed) begin
                ref_div   <= ref_pend;
                ref_armed <= 1'b0;
            end
            if (commit) begin
                unique case (tgt)
                    TGT_CFG: cfg_q <= word[CFG_W-1:0];
                    TGT_REF: ref_hold <= word[REF_W-1:0];
                    TGT_DIV: begin
                        div_pend  <= split_word(word);
                        div_armed <= 1'b1;
                        ref_pend  <= ref_hold;
                        ref_armed <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import ssl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    input  logic              ref_reload,
    input  logic              div_reload,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [REF_W-1:0]  ref_div,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swal_div,
    output logic              ser_out
);
    logic             sclk_rise, en_rise, en_fall, dat_s;
    logic [DIV_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    div_word_t        div_live;

    ssl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .din({ser_en, ser_dat, ser_clk}),
        .sclk_rise(sclk_rise), .en_rise(en_rise), .en_fall(en_fall), .dat(dat_s)
    );

    ssl_shifter u_shift (
        .clk(clk), .rst(rst), .start(en_rise), .shift(sclk_rise),
        .dat(dat_s), .shreg(shreg), .cnt(cnt)
    );

    ssl_stager u_stage (
        .clk(clk), .rst(rst), .commit(en_fall), .tgt(pick_target(cnt)),
        .word(shreg), .ref_reload(ref_reload), .div_reload(div_reload),
        .cfg_q(cfg_q), .ref_div(ref_div), .div_live(div_live)
    );

    assign main_div = div_live.main_v;
    assign swal_div = div_live.swal_v;
    assign ser_out  = cfg_q[CFG_DOUT_BIT] ? shreg[DIV_W-1] : cfg_q[CFG_GPO_BIT];
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker
    import ssl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_fall,
    input logic              ref_reload,
    input logic              div_reload,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [REF_W-1:0]  ref_div,
    input logic [MAIN_W-1:0] main_div,
    input logic [SWAL_W-1:0] swal_div,
    input logic [CNT_W-1:0]  cnt
);
    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_fall |=> $stable(cfg_q));

    // R3
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_reload |=> ($stable(main_div) && $stable(swal_div)));

    // R4
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_reload |=> $stable(ref_div));

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));
endmodule

bind synth_serial_loader ssl_checker u_chk (
    .clk(clk), .rst(rst), .en_fall(en_fall),
    .ref_reload(ref_reload), .div_reload(div_reload),
    .cfg_q(cfg_q), .ref_div(ref_div), .main_div(main_div),
    .swal_div(swal_div), .cnt(cnt)
);

// File: tb/tb_synth_serial_loader.sv
module tb_synth_serial_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic        ref_reload = 1'b0, div_reload = 1'b0;
    logic [7:0]  cfg_q;
    logic [15:0] ref_div;
    logic [11:0] main_div;
    logic [5:0]  swal_div;
    logic        ser_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    synth_serial_loader dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .ref_reload(ref_reload), .div_reload(div_reload),
        .cfg_q(cfg_q), .ref_div(ref_div), .main_div(main_div),
        .swal_div(swal_div), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        @(negedge clk);
        ser_en = 1'b1;
        wait_clk(4);
        for (int k = 0; k < n; k++) begin
            ser_dat = v[n-1-k];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
        end
        ser_en = 1'b0;
        wait_clk(6);
    endtask

    task automatic pulse_div();
        @(negedge clk); div_reload = 1'b1;
        @(negedge clk); div_reload = 1'b0;
        wait_clk(1);
    endtask

    task automatic pulse_ref();
        @(negedge clk); ref_reload = 1'b1;
        @(negedge clk); ref_reload = 1'b0;
        wait_clk(1);
    endtask

    task automatic t_reset();
        check("R8 cfg", 32'(cfg_q), 32'h80);
        check("R8 ref", 32'(ref_div), 32'd5);
        check("R8 main", 32'(main_div), 32'd5);
        check("R8 swal", 32'(swal_div), 32'd0);
        check("R8 out", 32'(ser_out), 32'd0);
    endtask

    task automatic t_cfg_and_gpo();
        send_bits(8, 32'h01);
        check("R1 cfg", 32'(cfg_q), 32'h01);
        check("R7 gpo high", 32'(ser_out), 32'd1);
        send_bits(8, 32'h80);
        check("R7 gpo low", 32'(ser_out), 32'd0);
    endtask

    task automatic t_discard();
        send_bits(12, 32'hABC);
        pulse_div();
        pulse_ref();
        check("R2 cfg", 32'(cfg_q), 32'h80);
        check("R2 main", 32'(main_div), 32'd5);
        check("R2 ref", 32'(ref_div), 32'd5);
    endtask

    task automatic t_div_write();
        logic [23:0] w;
        w = {12'h123, 6'h3F, 6'h2A};
        send_bits(24, 32'(w));
        check("R3 main before reload", 32'(main_div), 32'd5);
        pulse_ref();
        check("R3 main after ref strobe", 32'(main_div), 32'd5);
        pulse_div();
        check("R3 main", 32'(main_div), 32'h123);
        check("R3 swal", 32'(swal_div), 32'h2A);
    endtask

    task automatic t_ref_double_buffer();
        send_bits(16, 32'h1234);
        pulse_ref();
        check("R4 ref held", 32'(ref_div), 32'd5);
        send_bits(24, 32'({12'h456, 6'h00, 6'h11}));
        check("R4 ref armed not applied", 32'(ref_div), 32'd5);
        pulse_ref();
        check("R4 ref applied", 32'(ref_div), 32'h1234);
        check("R4 main waits", 32'(main_div), 32'h123);
        pulse_div();
        check("R4 main applied", 32'(main_div), 32'h456);
    endtask

    task automatic t_overlength();
        logic [29:0] v;
        v = 30'h1234_5678;
        send_bits(30, 32'(v));
        pulse_div();
        check("R5 main", 32'(main_div), 32'(v[23:12]));
        check("R5 swal", 32'(swal_div), 32'(v[5:0]));
    endtask

    task automatic t_chain();
        logic [23:0] x;
        x = 24'hA5C3_96;
        send_bits(8, 32'h40);
        check("R1 dout cfg", 32'(cfg_q), 32'h40);
        send_bits(24, 32'(x));
        check("R6 first chained bit", 32'(ser_out), 32'(x[23]));
        send_bits(4, 32'h0);
        check("R6 shifted chained bit", 32'(ser_out), 32'(x[19]));
        check("R2 cfg kept after 4 bits", 32'(cfg_q), 32'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_cfg_and_gpo();
        t_discard();
        t_div_write();
        t_ref_double_buffer();
        t_overlength();
        t_chain();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule